// File: doc/BRIEF.md
# Partitioned Logical and Bit-Count Unit

This block is a purely combinational 64-bit logic stage. It takes an operation code, a 4-bit data-length field and two 64-bit operands, A and B. It returns one 64-bit result. The three bitwise operations (AND, OR, XOR) always work on the full width. The set-bit count and the parity operations are split into lanes, and the data-length field picks the lane size: the whole doubleword, each 32-bit half, or each byte.

Parity uses only the least significant bit of each byte of A. A context word travels alongside the operands and comes out unchanged, so the enclosing pipeline can keep its own tags with the data. The stage holds no state and has no handshake. Any valid/ready flow control and any registers belong to the pipeline around it.

Operation codes on `op_i`: 0 = AND, 1 = OR, 2 = XOR, 3 = set-bit count, 4 = lane parity. Codes 5 to 7 are unsupported. Length codes on `len_i`: 1 = byte lanes, 4 = 32-bit lanes, 8 = one 64-bit lane.

Top module: `logic_bitcount_unit`

## Requirements
- R1: With `op_i` = 0, `result_o` equals A AND B over all 64 bits, for any `len_i`.
- R2: With `op_i` = 1, `result_o` equals A OR B over all 64 bits, for any `len_i`.
- R3: With `op_i` = 2, `result_o` equals A XOR B over all 64 bits, for any `len_i`.
- R4: With `op_i` = 3 and `len_i` = 8, `result_o` is the number of set bits in all 64 bits of A, zero-extended (64 gives 0x40).
- R5: With `op_i` = 3 and `len_i` = 4, bits 31:0 of the result hold the set-bit count of A[31:0] and bits 63:32 hold the count of A[63:32], each zero-extended within its half.
- R6: With `op_i` = 3 and `len_i` = 1, each result byte k holds the set-bit count of byte k of A. A full byte gives 8 without overflow.
- R7: With `op_i` = 4 and `len_i` = 8, result bit 0 is the XOR of bit 0 of all eight bytes of A (bits 0, 8, …, 56).
- R8: With `op_i` = 4 and `len_i` = 4, result bit 0 is the XOR of bits 0, 8, 16 and 24 of A, and result bit 32 is the XOR of bits 32, 40, 48 and 56 of A.
- R9: Parity results are zero-extended: for `len_i` = 8 every bit above bit 0 is zero, and for `len_i` = 4 every bit other than bits 0 and 32 is zero.
- R10: `ctx_o` equals `ctx_i` bit for bit, whatever the operation.
- R11: Operation codes 5 to 7, set-bit count with a length other than 1, 4 or 8, and parity with a length other than 4 or 8 all give an all-zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0 AND, 1 OR, 2 XOR, 3 count, 4 parity) |
| len_i | input | 4 | Lane size selector (1, 4 or 8 bytes) |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B (used only by bitwise operations) |
| ctx_i | input | CTX_W (16) | Opaque context travelling with the operands |
| result_o | output | 64 | Operation result |
| ctx_o | output | CTX_W (16) | Context copied from `ctx_i` |

## Verification
The assertions are immediate checks that run whenever the inputs change. They assume every input is stable and free of X or Z values when it is evaluated, since an unknown operation code or length would make the selection ambiguous. The bench keeps within this: it drives all inputs to known values at time zero, and it changes them only on the falling edge of its sampling clock. Each result is read a quarter period later, once the combinational paths have settled.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  typedef enum logic [2:0] {
    LOP_AND    = 3'd0,
    LOP_OR     = 3'd1,
    LOP_XOR    = 3'd2,
    LOP_POPCNT = 3'd3,
    LOP_PARITY = 3'd4
  } lop_e;

  localparam logic [3:0] LEN_BYTE  = 4'd1;
  localparam logic [3:0] LEN_WORD  = 4'd4;
  localparam logic [3:0] LEN_DWORD = 4'd8;
endpackage

// File: rtl/lbu_bitwise.sv
module lbu_bitwise #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] xor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign xor_o = a_i ^ b_i;
endmodule

// File: rtl/lbu_popcount.sv
module lbu_popcount #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] lane_cnt_o,
  output logic [DATA_W-1:0] half_cnt_o,
  output logic [DATA_W-1:0] full_cnt_o
);
  localparam int NLANES = DATA_W / LANE_W;
  localparam int LPH    = NLANES / 2;
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(LANE_W + 1);
  localparam int HCNT_W = $clog2(HALF_W + 1);
  localparam int DCNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  lane_cnt [NLANES];
  logic [HCNT_W-1:0] half_cnt [2];

  // per-lane bit counters
  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic [CNT_W-1:0] c;
    always_comb begin
      c = '0;
      for (int k = 0; k < LANE_W; k++) c = c + CNT_W'(a_i[g*LANE_W + k]);
    end
    assign lane_cnt[g] = c;
    assign lane_cnt_o[g*LANE_W +: LANE_W] = LANE_W'(c);
  end

  // half sums reuse lane counts
  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HCNT_W-1:0] s;
    always_comb begin
      s = '0;
      for (int l = 0; l < LPH; l++) s = s + HCNT_W'(lane_cnt[h*LPH + l]);
    end
    assign half_cnt[h] = s;
    assign half_cnt_o[h*HALF_W +: HALF_W] = HALF_W'(s);
  end

  logic [DCNT_W-1:0] full_sum;
  assign full_sum   = DCNT_W'(half_cnt[0]) + DCNT_W'(half_cnt[1]);
  assign full_cnt_o = DATA_W'(full_sum);
endmodule

// File: rtl/lbu_parity.sv
module lbu_parity #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] half_par_o,
  output logic [DATA_W-1:0] full_par_o
);
  localparam int NLANES = DATA_W / LANE_W;
  localparam int LPH    = NLANES / 2;
  localparam int HALF_W = DATA_W / 2;

  logic [NLANES-1:0] lsb;
  logic [1:0]        hp;

  for (genvar g = 0; g < NLANES; g++) begin : g_lsb
    assign lsb[g] = a_i[g*LANE_W];
  end

  for (genvar h = 0; h < 2; h++) begin : g_hp
    assign hp[h] = ^lsb[h*LPH +: LPH];
    assign half_par_o[h*HALF_W +: HALF_W] = HALF_W'(hp[h]);
  end

  assign full_par_o = DATA_W'(hp[0] ^ hp[1]);
endmodule

// File: rtl/logic_bitcount_unit.sv
module logic_bitcount_unit #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int CTX_W  = 16
) (
  input  logic [2:0]        op_i,
  input  logic [3:0]        len_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic [DATA_W-1:0] result_o,
  output logic [CTX_W-1:0]  ctx_o
);
  import lbu_pkg::*;

  logic [DATA_W-1:0] and_r, or_r, xor_r;
  logic [DATA_W-1:0] cnt_lane, cnt_half, cnt_full;
  logic [DATA_W-1:0] par_half, par_full;

  lbu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a_i(a_i), .b_i(b_i), .and_o(and_r), .or_o(or_r), .xor_o(xor_r)
  );

  lbu_popcount #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_popcount (
    .a_i(a_i), .lane_cnt_o(cnt_lane), .half_cnt_o(cnt_half), .full_cnt_o(cnt_full)
  );

  lbu_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_parity (
    .a_i(a_i), .half_par_o(par_half), .full_par_o(par_full)
  );

  always_comb begin
    result_o = '0;
    case (lop_e'(op_i))
      LOP_AND: result_o = and_r;
      LOP_OR:  result_o = or_r;
      LOP_XOR: result_o = xor_r;
      LOP_POPCNT: begin
        case (len_i)
          LEN_BYTE:  result_o = cnt_lane;
          LEN_WORD:  result_o = cnt_half;
          LEN_DWORD: result_o = cnt_full;
          default:   result_o = '0;
        endcase
      end
      LOP_PARITY: begin
        case (len_i)
          LEN_WORD:  result_o = par_half;
          LEN_DWORD: result_o = par_full;
          default:   result_o = '0;
        endcase
      end
      default: result_o = '0;
    endcase
  end

  assign ctx_o = ctx_i;
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int CTX_W  = 16
) (
  input logic [2:0]        op_i,
  input logic [3:0]        len_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [CTX_W-1:0]  ctx_i,
  input logic [DATA_W-1:0] result_o,
  input logic [CTX_W-1:0]  ctx_o
);
  localparam int NLANES = DATA_W / LANE_W;
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    a_r10_ctx_pass: assert (ctx_o == ctx_i);

    if (op_i == 3'd0) a_r1_and: assert (result_o == (a_i & b_i));
    if (op_i == 3'd1) a_r2_or:  assert (result_o == (a_i | b_i));
    if (op_i == 3'd2) a_r3_xor: assert (result_o == (a_i ^ b_i));

    if (op_i == 3'd3 && len_i == 4'd8)
      a_r4_full_count: assert (result_o == DATA_W'($countones(a_i)));

    if (op_i == 3'd3 && len_i == 4'd4) begin
      a_r5_half_lo: assert (result_o[HALF_W-1:0] == HALF_W'($countones(a_i[HALF_W-1:0])));
      a_r5_half_hi: assert (result_o[DATA_W-1:HALF_W] == HALF_W'($countones(a_i[DATA_W-1:HALF_W])));
    end

    if (op_i == 3'd3 && len_i == 4'd1) begin
      for (int l = 0; l < NLANES; l++) begin
        a_r6_lane_count: assert (result_o[l*LANE_W +: LANE_W] ==
                                 LANE_W'($countones(a_i[l*LANE_W +: LANE_W])));
      end
    end

    if (op_i == 3'd4 && len_i == 4'd8)
      a_r9_full_zext: assert (result_o[DATA_W-1:1] == '0);

    if (op_i == 3'd4 && len_i == 4'd4) begin
      a_r9_half_zext_lo: assert (result_o[HALF_W-1:1] == '0);
      a_r9_half_zext_hi: assert (result_o[DATA_W-1:HALF_W+1] == '0);
    end

    if (op_i > 3'd4 ||
        (op_i == 3'd3 && len_i != 4'd1 && len_i != 4'd4 && len_i != 4'd8) ||
        (op_i == 3'd4 && len_i != 4'd4 && len_i != 4'd8))
      a_r11_unsupported_zero: assert (result_o == '0);
  end
endmodule

bind logic_bitcount_unit lbu_checker #(
  .DATA_W(DATA_W), .LANE_W(LANE_W), .CTX_W(CTX_W)
) u_chk (
  .op_i(op_i), .len_i(len_i), .a_i(a_i), .b_i(b_i),
  .ctx_i(ctx_i), .result_o(result_o), .ctx_o(ctx_o)
);

// File: tb/logic_bitcount_unit_tb.sv
module logic_bitcount_unit_tb;
  localparam int CTX_W = 16;
  localparam int NVEC  = 14;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  len;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 4'd8, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_00FF_1234},
    '{3'd1, 4'd1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_00FF_1234},
    '{3'd2, 4'd4, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FF00_00FF_1234},
    '{3'd0, 4'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_0000_0000},
    '{3'd3, 4'd8, 64'hDEAD_BEEF_CAFE_F00D, 64'h0},
    '{3'd3, 4'd4, 64'hDEAD_BEEF_CAFE_F00D, 64'h0},
    '{3'd3, 4'd1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0},
    '{3'd3, 4'd1, 64'h8001_7F80_0103_0FF0, 64'h0},
    '{3'd4, 4'd8, 64'h0100_0001_0000_0101, 64'h0},
    '{3'd4, 4'd4, 64'h0100_0001_0000_0101, 64'h0},
    '{3'd4, 4'd4, 64'hFEFF_FFFE_0100_0000, 64'h0},
    '{3'd4, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0},
    '{3'd3, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},
    '{3'd6, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]       op_i  = '0;
  logic [3:0]       len_i = '0;
  logic [63:0]      a_i   = '0;
  logic [63:0]      b_i   = '0;
  logic [CTX_W-1:0] ctx_i = '0;
  logic [63:0]      result_o;
  logic [CTX_W-1:0] ctx_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic_bitcount_unit #(.DATA_W(64), .LANE_W(8), .CTX_W(CTX_W)) u_dut (
    .op_i(op_i), .len_i(len_i), .a_i(a_i), .b_i(b_i),
    .ctx_i(ctx_i), .result_o(result_o), .ctx_o(ctx_o)
  );

  function automatic logic [63:0] model(logic [2:0] op, logic [3:0] len,
                                        logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    int n;
    case (op)
      3'd0: r = a & b;
      3'd1: r = a | b;
      3'd2: r = a ^ b;
      3'd3: begin
        if (len == 4'd8) begin
          n = 0;
          for (int i = 0; i < 64; i++) n += int'(a[i]);
          r = 64'(n);
        end else if (len == 4'd4) begin
          for (int h = 0; h < 2; h++) begin
            n = 0;
            for (int i = 0; i < 32; i++) n += int'(a[h*32 + i]);
            r[h*32 +: 32] = 32'(n);
          end
        end else if (len == 4'd1) begin
          for (int y = 0; y < 8; y++) begin
            n = 0;
            for (int i = 0; i < 8; i++) n += int'(a[y*8 + i]);
            r[y*8 +: 8] = 8'(n);
          end
        end
      end
      3'd4: begin
        if (len == 4'd8) begin
          for (int y = 0; y < 8; y++) r[0] = r[0] ^ a[y*8];
        end else if (len == 4'd4) begin
          for (int y = 0; y < 4; y++) begin
            r[0]  = r[0]  ^ a[y*8];
            r[32] = r[32] ^ a[32 + y*8];
          end
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(logic [2:0] op, logic [3:0] len);
    if (op == 3'd0) return "R1";
    if (op == 3'd1) return "R2";
    if (op == 3'd2) return "R3";
    if (op == 3'd3 && len == 4'd8) return "R4";
    if (op == 3'd3 && len == 4'd4) return "R5";
    if (op == 3'd3 && len == 4'd1) return "R6";
    if (op == 3'd4 && len == 4'd8) return "R7/R9";
    if (op == 3'd4 && len == 4'd4) return "R8/R9";
    return "R11";
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic [3:0] len, logic [63:0] a,
                       logic [63:0] b, logic [CTX_W-1:0] ctx);
    @(negedge clk);
    op_i = op; len_i = len; a_i = a; b_i = b; ctx_i = ctx;
    #5;
  endtask

  initial begin
    // start state: all-zero inputs give zero result and zero context
    #5;
    check("R1 start", result_o, 64'h0);
    check("R10 start", 64'(ctx_o), 64'h0);

    foreach (VECS[i]) begin
      apply(VECS[i].op, VECS[i].len, VECS[i].a, VECS[i].b, CTX_W'(16'hA5C0 + i));
      check(req_of(VECS[i].op, VECS[i].len), result_o,
            model(VECS[i].op, VECS[i].len, VECS[i].a, VECS[i].b));
      check("R10", 64'(ctx_o), 64'(CTX_W'(16'hA5C0 + i)));
    end

    // directed corners with hand-computed values
    apply(3'd3, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'hFFFF);
    check("R6 full bytes", result_o, 64'h0808_0808_0808_0808);
    check("R10 ones", 64'(ctx_o), 64'h0000_0000_0000_FFFF);
    apply(3'd3, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0001);
    check("R5 full halves", result_o, 64'h0000_0020_0000_0020);
    apply(3'd3, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0002);
    check("R4 all ones", result_o, 64'h40);
    apply(3'd3, 4'd8, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0003);
    check("R4 zero", result_o, 64'h0);
    apply(3'd4, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0004);
    check("R7 even", result_o, 64'h0);
    apply(3'd4, 4'd8, 64'h0000_0000_0000_0001, 64'h0, 16'h0005);
    check("R7 odd", result_o, 64'h1);
    apply(3'd4, 4'd8, 64'hFEFE_FEFE_FEFE_FEFE, 64'h0, 16'h0006);
    check("R9 upper bits ignored", result_o, 64'h0);
    apply(3'd4, 4'd4, 64'h0000_0001_0000_0001, 64'h0, 16'h0007);
    check("R8 both halves", result_o, 64'h0000_0001_0000_0001);
    apply(3'd4, 4'd4, 64'h0101_0000_0000_0100, 64'h0, 16'h0008);
    check("R8 cancel high", result_o, 64'h0000_0000_0000_0001);
    apply(3'd4, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 16'h0009);
    check("R11 parity bytes", result_o, 64'h0);
    apply(3'd5, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h000A);
    check("R11 op5", result_o, 64'h0);
    apply(3'd7, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 16'h000B);
    check("R11 op7", result_o, 64'h0);
    apply(3'd2, 4'd1, 64'hAAAA_AAAA_5555_5555, 64'hFFFF_0000_FFFF_0000, 16'h000C);
    check("R3 lanes ignored", result_o, 64'h5555_AAAA_AAAA_5555);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-all actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule